// File: doc/BRIEF.md
# Dual-Issue Dispatch Arbiter

This combinational block sits between the decode stage and the reservation stations of a two-wide out-of-order core. Each cycle it receives two decoded instruction slots in program order, with the opcode, register indexes and looked-up operand state of each. It also receives the next two free reorder-buffer tags, one availability flag per tag, and a ready flag from each of the three stations (branch, ALU, load/store). From these it decides whether zero, one or two instructions leave this cycle. For each slot it reports the target station and the tag assigned to it, and it returns corrected operand fields. It also raises write requests toward the register-status table for destination registers.

Dispatch is strictly in order. The younger slot can only leave together with the older one, and only when the two target different stations. When both leave, any source of the younger slot that names the older slot's destination is redirected to wait on the older slot's tag.

Top module: `dispatch_pair`

## Requirements
- R1: The station code is 0 (branch) for opcodes 1100011, 1101111 and 1100111. It is 2 (load/store) for opcodes 0000011 and 0100011. It is 1 (ALU) for every other opcode.
- R2: Slot 0 dispatches exactly when it is valid, its station's ready flag is high, and the first ROB availability flag is high.
- R3: When slot 0 does not dispatch, slot 1 does not dispatch, whatever its own state.
- R4: Slot 1 dispatches exactly when slot 0 dispatches, slot 1 is valid, its station differs from slot 0's, its station is ready, and the second ROB availability flag is high.
- R5: When both slots target the same station, at most slot 0 dispatches.
- R6: Slot 0 is given the first free ROB tag and slot 1 the second.
- R7: When slot 0 dispatches and writes a nonzero rd that equals a used rs1 or rs2 of slot 1, that slot-1 operand is output not-ready, with value 0 and tag equal to the first ROB tag.
- R8: A destination of x0 triggers no forwarding and no register-status request.
- R9: rs1 is unused for opcodes 0110111, 0010111 and 1101111. rs2 is used only for opcodes 1100011, 0100011 and 0110011. An unused operand is output ready, whatever its input flag.
- R10: A register-status request is raised for a slot exactly when it dispatches and its opcode writes a register (any opcode except 1100011 and 0100011) with rd not 0. The request carries that rd and the slot's ROB tag.
- R11: A used operand that is not forwarded passes its ready flag, value and tag through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_opcode | input | 7 | Slot 0 major opcode |
| s0_rd | input | 5 | Slot 0 destination index |
| s0_rs1 | input | 5 | Slot 0 first source index |
| s0_rs2 | input | 5 | Slot 0 second source index |
| s0_a_rdy | input | 1 | Slot 0 first operand ready |
| s0_a_val | input | XLEN | Slot 0 first operand value |
| s0_a_tag | input | TAG_W | Slot 0 first operand producer tag |
| s0_b_rdy | input | 1 | Slot 0 second operand ready |
| s0_b_val | input | XLEN | Slot 0 second operand value |
| s0_b_tag | input | TAG_W | Slot 0 second operand producer tag |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_opcode | input | 7 | Slot 1 major opcode |
| s1_rd | input | 5 | Slot 1 destination index |
| s1_rs1 | input | 5 | Slot 1 first source index |
| s1_rs2 | input | 5 | Slot 1 second source index |
| s1_a_rdy | input | 1 | Slot 1 first operand ready |
| s1_a_val | input | XLEN | Slot 1 first operand value |
| s1_a_tag | input | TAG_W | Slot 1 first operand producer tag |
| s1_b_rdy | input | 1 | Slot 1 second operand ready |
| s1_b_val | input | XLEN | Slot 1 second operand value |
| s1_b_tag | input | TAG_W | Slot 1 second operand producer tag |
| rob_tag0 | input | TAG_W | First free ROB tag |
| rob_tag1 | input | TAG_W | Second free ROB tag |
| rob_avail0 | input | 1 | First free tag may be taken |
| rob_avail1 | input | 1 | Second free tag may be taken |
| br_rdy | input | 1 | Branch station can accept |
| alu_rdy | input | 1 | ALU station can accept |
| ls_rdy | input | 1 | Load/store station can accept |
| s0_go | output | 1 | Slot 0 dispatches |
| s0_stn | output | 2 | Slot 0 station code |
| s0_tag | output | TAG_W | ROB tag for slot 0 |
| s0_a_rdy_o | output | 1 | Slot 0 first operand ready, corrected |
| s0_a_val_o | output | XLEN | Slot 0 first operand value, corrected |
| s0_a_tag_o | output | TAG_W | Slot 0 first operand tag, corrected |
| s0_b_rdy_o | output | 1 | Slot 0 second operand ready, corrected |
| s0_b_val_o | output | XLEN | Slot 0 second operand value, corrected |
| s0_b_tag_o | output | TAG_W | Slot 0 second operand tag, corrected |
| s1_go | output | 1 | Slot 1 dispatches |
| s1_stn | output | 2 | Slot 1 station code |
| s1_tag | output | TAG_W | ROB tag for slot 1 |
| s1_a_rdy_o | output | 1 | Slot 1 first operand ready, corrected |
| s1_a_val_o | output | XLEN | Slot 1 first operand value, corrected |
| s1_a_tag_o | output | TAG_W | Slot 1 first operand tag, corrected |
| s1_b_rdy_o | output | 1 | Slot 1 second operand ready, corrected |
| s1_b_val_o | output | XLEN | Slot 1 second operand value, corrected |
| s1_b_tag_o | output | TAG_W | Slot 1 second operand tag, corrected |
| rs_we0 | output | 1 | Register-status request from slot 0 |
| rs_rd0 | output | 5 | Register index for slot 0 request |
| rs_tag0 | output | TAG_W | Tag for slot 0 request |
| rs_we1 | output | 1 | Register-status request from slot 1 (applies after slot 0's) |
| rs_rd1 | output | 5 | Register index for slot 1 request |
| rs_tag1 | output | TAG_W | Tag for slot 1 request |

## Verification
The block holds no state, so any fault in its decode or grant logic shows at the ports in the same cycle the inputs are applied. A wrong station decode shows as a wrong station code, or as a grant that follows the wrong ready flag. A broken grant term lets slot 1 out past a blocked slot 0, or lets both slots claim one station. A faulty comparison in the forwarding path leaves a dependent operand marked ready with a stale value, or redirects a source that named x0. Each of these is visible on the first input pattern that exercises it.

// File: rtl/disp_pkg.sv
package disp_pkg;
   typedef enum logic [1:0] {
      STN_BR  = 2'd0,
      STN_ALU = 2'd1,
      STN_LS  = 2'd2,
      STN_NIL = 2'd3
   } stn_e;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_REG    = 7'b0110011;

   typedef struct packed {
      stn_e stn;
      logic use_a;
      logic use_b;
      logic wr_rd;
   } dec_t;
endpackage

// File: rtl/disp_class.sv
module disp_class
   import disp_pkg::*;
(
   input  logic [6:0] opcode,
   output dec_t       dec
);
   always_comb begin
      dec.stn   = STN_ALU;
      dec.use_a = 1'b1;
      dec.use_b = 1'b0;
      dec.wr_rd = 1'b1;
      unique case (opcode)
         OPC_BRANCH: begin
            dec.stn   = STN_BR;
            dec.use_b = 1'b1;
            dec.wr_rd = 1'b0;
         end
         OPC_JAL: begin
            dec.stn   = STN_BR;
            dec.use_a = 1'b0;
         end
         OPC_JALR:  dec.stn = STN_BR;
         OPC_LOAD:  dec.stn = STN_LS;
         OPC_STORE: begin
            dec.stn   = STN_LS;
            dec.use_b = 1'b1;
            dec.wr_rd = 1'b0;
         end
         OPC_LUI, OPC_AUIPC: dec.use_a = 1'b0;
         OPC_REG:   dec.use_b = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/disp_grant.sv
module disp_grant
   import disp_pkg::*;
(
   input  logic v0,
   input  logic v1,
   input  stn_e stn0,
   input  stn_e stn1,
   input  logic br_rdy,
   input  logic alu_rdy,
   input  logic ls_rdy,
   input  logic avail0,
   input  logic avail1,
   output logic go0,
   output logic go1
);
   logic ok0, ok1;

   function automatic logic stn_ok(input stn_e s, input logic b, input logic a,
                                   input logic l);
      unique case (s)
         STN_BR:  stn_ok = b;
         STN_ALU: stn_ok = a;
         STN_LS:  stn_ok = l;
         default: stn_ok = 1'b0;
      endcase
   endfunction

   always_comb begin
      ok0 = stn_ok(stn0, br_rdy, alu_rdy, ls_rdy);
      ok1 = stn_ok(stn1, br_rdy, alu_rdy, ls_rdy);
      go0 = v0 && ok0 && avail0;
      go1 = go0 && v1 && ok1 && avail1 && (stn1 != stn0);
   end
endmodule

// File: rtl/disp_opnd.sv
module disp_opnd #(
   parameter int XLEN  = 32,
   parameter int TAG_W = 3
) (
   input  logic             used,
   input  logic             fwd_hit,
   input  logic [TAG_W-1:0] fwd_tag,
   input  logic             rdy_i,
   input  logic [XLEN-1:0]  val_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             rdy_o,
   output logic [XLEN-1:0]  val_o,
   output logic [TAG_W-1:0] tag_o
);
   always_comb begin
      rdy_o = rdy_i;
      val_o = val_i;
      tag_o = tag_i;
      if (!used) begin
         rdy_o = 1'b1;
      end else if (fwd_hit) begin
         rdy_o = 1'b0;
         val_o = '0;
         tag_o = fwd_tag;
      end
   end
endmodule

// File: rtl/dispatch_pair.sv
module dispatch_pair
   import disp_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int TAG_W = 3
) (
   input  logic             s0_valid,
   input  logic [6:0]       s0_opcode,
   input  logic [4:0]       s0_rd,
   input  logic [4:0]       s0_rs1,
   input  logic [4:0]       s0_rs2,
   input  logic             s0_a_rdy,
   input  logic [XLEN-1:0]  s0_a_val,
   input  logic [TAG_W-1:0] s0_a_tag,
   input  logic             s0_b_rdy,
   input  logic [XLEN-1:0]  s0_b_val,
   input  logic [TAG_W-1:0] s0_b_tag,
   input  logic             s1_valid,
   input  logic [6:0]       s1_opcode,
   input  logic [4:0]       s1_rd,
   input  logic [4:0]       s1_rs1,
   input  logic [4:0]       s1_rs2,
   input  logic             s1_a_rdy,
   input  logic [XLEN-1:0]  s1_a_val,
   input  logic [TAG_W-1:0] s1_a_tag,
   input  logic             s1_b_rdy,
   input  logic [XLEN-1:0]  s1_b_val,
   input  logic [TAG_W-1:0] s1_b_tag,
   input  logic [TAG_W-1:0] rob_tag0,
   input  logic [TAG_W-1:0] rob_tag1,
   input  logic             rob_avail0,
   input  logic             rob_avail1,
   input  logic             br_rdy,
   input  logic             alu_rdy,
   input  logic             ls_rdy,
   output logic             s0_go,
   output logic [1:0]       s0_stn,
   output logic [TAG_W-1:0] s0_tag,
   output logic             s0_a_rdy_o,
   output logic [XLEN-1:0]  s0_a_val_o,
   output logic [TAG_W-1:0] s0_a_tag_o,
   output logic             s0_b_rdy_o,
   output logic [XLEN-1:0]  s0_b_val_o,
   output logic [TAG_W-1:0] s0_b_tag_o,
   output logic             s1_go,
   output logic [1:0]       s1_stn,
   output logic [TAG_W-1:0] s1_tag,
   output logic             s1_a_rdy_o,
   output logic [XLEN-1:0]  s1_a_val_o,
   output logic [TAG_W-1:0] s1_a_tag_o,
   output logic             s1_b_rdy_o,
   output logic [XLEN-1:0]  s1_b_val_o,
   output logic [TAG_W-1:0] s1_b_tag_o,
   output logic             rs_we0,
   output logic [4:0]       rs_rd0,
   output logic [TAG_W-1:0] rs_tag0,
   output logic             rs_we1,
   output logic [4:0]       rs_rd1,
   output logic [TAG_W-1:0] rs_tag1
);
   localparam int NSLOT = 2;
   localparam int NOPND = 2 * NSLOT;

   if (XLEN < 1) begin : g_bad_xlen
      $error("dispatch_pair: XLEN must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dispatch_pair: TAG_W must be at least 1");
   end

   logic [6:0]       opc   [NSLOT];
   logic [4:0]       rd    [NSLOT];
   logic [TAG_W-1:0] rtag  [NSLOT];
   dec_t             dec   [NSLOT];
   logic             go    [NSLOT];

   logic [4:0]       src_idx [NOPND];
   logic             o_used  [NOPND];
   logic             o_hit   [NOPND];
   logic             i_rdy   [NOPND];
   logic [XLEN-1:0]  i_val   [NOPND];
   logic [TAG_W-1:0] i_tag   [NOPND];
   logic             o_rdy   [NOPND];
   logic [XLEN-1:0]  o_val   [NOPND];
   logic [TAG_W-1:0] o_tag   [NOPND];

   logic             old_writes;

   assign opc[0]  = s0_opcode;
   assign opc[1]  = s1_opcode;
   assign rd[0]   = s0_rd;
   assign rd[1]   = s1_rd;
   assign rtag[0] = rob_tag0;
   assign rtag[1] = rob_tag1;

   assign src_idx[0] = s0_rs1;
   assign src_idx[1] = s0_rs2;
   assign src_idx[2] = s1_rs1;
   assign src_idx[3] = s1_rs2;
   assign i_rdy[0] = s0_a_rdy;  assign i_val[0] = s0_a_val;  assign i_tag[0] = s0_a_tag;
   assign i_rdy[1] = s0_b_rdy;  assign i_val[1] = s0_b_val;  assign i_tag[1] = s0_b_tag;
   assign i_rdy[2] = s1_a_rdy;  assign i_val[2] = s1_a_val;  assign i_tag[2] = s1_a_tag;
   assign i_rdy[3] = s1_b_rdy;  assign i_val[3] = s1_b_val;  assign i_tag[3] = s1_b_tag;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      disp_class u_class (
         .opcode (opc[g]),
         .dec    (dec[g])
      );
   end

   disp_grant u_grant (
      .v0      (s0_valid),
      .v1      (s1_valid),
      .stn0    (dec[0].stn),
      .stn1    (dec[1].stn),
      .br_rdy  (br_rdy),
      .alu_rdy (alu_rdy),
      .ls_rdy  (ls_rdy),
      .avail0  (rob_avail0),
      .avail1  (rob_avail1),
      .go0     (go[0]),
      .go1     (go[1])
   );

   assign old_writes = go[0] && dec[0].wr_rd && (rd[0] != 5'd0);

   for (genvar k = 0; k < NOPND; k++) begin : g_opnd
      localparam int SLOT = k / 2;
      if (k % 2 == 0) begin : g_a
         assign o_used[k] = dec[SLOT].use_a;
      end else begin : g_b
         assign o_used[k] = dec[SLOT].use_b;
      end
      if (SLOT == 0) begin : g_oldest
         assign o_hit[k] = 1'b0;
      end else begin : g_younger
         assign o_hit[k] = old_writes && (src_idx[k] == rd[0]);
      end
      disp_opnd #(.XLEN(XLEN), .TAG_W(TAG_W)) u_opnd (
         .used    (o_used[k]),
         .fwd_hit (o_hit[k]),
         .fwd_tag (rob_tag0),
         .rdy_i   (i_rdy[k]),
         .val_i   (i_val[k]),
         .tag_i   (i_tag[k]),
         .rdy_o   (o_rdy[k]),
         .val_o   (o_val[k]),
         .tag_o   (o_tag[k])
      );
   end

   assign s0_go  = go[0];
   assign s1_go  = go[1];
   assign s0_stn = dec[0].stn;
   assign s1_stn = dec[1].stn;
   assign s0_tag = rtag[0];
   assign s1_tag = rtag[1];

   assign s0_a_rdy_o = o_rdy[0];  assign s0_a_val_o = o_val[0];  assign s0_a_tag_o = o_tag[0];
   assign s0_b_rdy_o = o_rdy[1];  assign s0_b_val_o = o_val[1];  assign s0_b_tag_o = o_tag[1];
   assign s1_a_rdy_o = o_rdy[2];  assign s1_a_val_o = o_val[2];  assign s1_a_tag_o = o_tag[2];
   assign s1_b_rdy_o = o_rdy[3];  assign s1_b_val_o = o_val[3];  assign s1_b_tag_o = o_tag[3];

   assign rs_we0  = old_writes;
   assign rs_rd0  = rd[0];
   assign rs_tag0 = rtag[0];
   assign rs_we1  = go[1] && dec[1].wr_rd && (rd[1] != 5'd0);
   assign rs_rd1  = rd[1];
   assign rs_tag1 = rtag[1];
endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
   parameter int TAG_W = 3
) (
   input logic             s0_valid,
   input logic             rob_avail0,
   input logic             rob_avail1,
   input logic [TAG_W-1:0] rob_tag0,
   input logic [6:0]       s1_opcode,
   input logic [4:0]       s1_rs1,
   input logic             s0_go,
   input logic             s1_go,
   input logic [1:0]       s0_stn,
   input logic [1:0]       s1_stn,
   input logic             s1_a_rdy_o,
   input logic [TAG_W-1:0] s1_a_tag_o,
   input logic             rs_we0,
   input logic [4:0]       rs_rd0,
   input logic             rs_we1,
   input logic [4:0]       rs_rd1
);
   always_comb begin
      p_in_order_r3: assert (s0_go || !s1_go);
      p_slot0_res_r2: assert (!s0_go || (s0_valid && rob_avail0));
      p_slot1_rob_r4: assert (!s1_go || rob_avail1);
      p_no_share_r5: assert (!(s0_go && s1_go) || (s0_stn != s1_stn));
      p_x0_quiet0_r8: assert (!rs_we0 || (rs_rd0 != 5'd0));
      p_x0_quiet1_r8: assert (!rs_we1 || (rs_rd1 != 5'd0));
      p_status_go_r10: assert ((!rs_we0 || s0_go) && (!rs_we1 || s1_go));
      // R7: a register-register younger op reading the older op's rd must wait on its tag
      p_fwd_r7: assert (!(s1_go && rs_we0 && (s1_opcode == 7'b0110011) && (s1_rs1 == rs_rd0))
                        || (!s1_a_rdy_o && (s1_a_tag_o == rob_tag0)));
   end
endmodule

bind dispatch_pair disp_chk #(.TAG_W(TAG_W)) u_chk (
   .s0_valid   (s0_valid),
   .rob_avail0 (rob_avail0),
   .rob_avail1 (rob_avail1),
   .rob_tag0   (rob_tag0),
   .s1_opcode  (s1_opcode),
   .s1_rs1     (s1_rs1),
   .s0_go      (s0_go),
   .s1_go      (s1_go),
   .s0_stn     (s0_stn),
   .s1_stn     (s1_stn),
   .s1_a_rdy_o (s1_a_rdy_o),
   .s1_a_tag_o (s1_a_tag_o),
   .rs_we0     (rs_we0),
   .rs_rd0     (rs_rd0),
   .rs_we1     (rs_we1),
   .rs_rd1     (rs_rd1)
);

// File: tb/dispatch_pair_tb.sv
module dispatch_pair_tb;
   localparam int XLEN  = 32;
   localparam int TAG_W = 3;

   localparam logic [6:0] BR  = 7'b1100011, JAL = 7'b1101111, JALR = 7'b1100111;
   localparam logic [6:0] LD  = 7'b0000011, ST  = 7'b0100011, LUI  = 7'b0110111;
   localparam logic [6:0] RR  = 7'b0110011, IMM = 7'b0010011;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             s0_valid, s1_valid;
   logic [6:0]       s0_opcode, s1_opcode;
   logic [4:0]       s0_rd, s0_rs1, s0_rs2, s1_rd, s1_rs1, s1_rs2;
   logic             s0_a_rdy, s0_b_rdy, s1_a_rdy, s1_b_rdy;
   logic [XLEN-1:0]  s0_a_val, s0_b_val, s1_a_val, s1_b_val;
   logic [TAG_W-1:0] s0_a_tag, s0_b_tag, s1_a_tag, s1_b_tag;
   logic [TAG_W-1:0] rob_tag0, rob_tag1;
   logic             rob_avail0, rob_avail1, br_rdy, alu_rdy, ls_rdy;

   logic             s0_go, s1_go;
   logic [1:0]       s0_stn, s1_stn;
   logic [TAG_W-1:0] s0_tag, s1_tag;
   logic             s0_a_rdy_o, s0_b_rdy_o, s1_a_rdy_o, s1_b_rdy_o;
   logic [XLEN-1:0]  s0_a_val_o, s0_b_val_o, s1_a_val_o, s1_b_val_o;
   logic [TAG_W-1:0] s0_a_tag_o, s0_b_tag_o, s1_a_tag_o, s1_b_tag_o;
   logic             rs_we0, rs_we1;
   logic [4:0]       rs_rd0, rs_rd1;
   logic [TAG_W-1:0] rs_tag0, rs_tag1;

   int n_chk  = 0;
   int n_fail = 0;

   dispatch_pair #(.XLEN(XLEN), .TAG_W(TAG_W)) u_dut (.*);

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      s0_valid = 0; s1_valid = 0;
      s0_opcode = IMM; s1_opcode = IMM;
      s0_rd = 0; s0_rs1 = 0; s0_rs2 = 0; s1_rd = 0; s1_rs1 = 0; s1_rs2 = 0;
      s0_a_rdy = 1; s0_b_rdy = 1; s1_a_rdy = 1; s1_b_rdy = 1;
      s0_a_val = 32'h11; s0_b_val = 32'h22; s1_a_val = 32'h33; s1_b_val = 32'h44;
      s0_a_tag = 3'd1; s0_b_tag = 3'd2; s1_a_tag = 3'd3; s1_b_tag = 3'd4;
      rob_tag0 = 3'd5; rob_tag1 = 3'd6;
      rob_avail0 = 1; rob_avail1 = 1; br_rdy = 1; alu_rdy = 1; ls_rdy = 1;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      idle();
      settle();
      chk("R2", "idle s0_go", s0_go, 0);
      chk("R3", "idle s1_go", s1_go, 0);
      chk("R10", "idle we0", rs_we0, 0);
      chk("R10", "idle we1", rs_we1, 0);
   endtask

   task automatic t_class();
      logic [6:0] ops [8] = '{BR, JAL, JALR, LD, ST, LUI, RR, IMM};
      logic [1:0] exp [8] = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1, 2'd1};
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #1;
         idle(); s0_valid = 1; s0_opcode = ops[i];
         settle();
         chk("R1", "s0 station", s0_stn, exp[i]);
         chk("R2", "s0 go all ready", s0_go, 1);
      end
   endtask

   task automatic t_block();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = RR; alu_rdy = 0;
      s1_valid = 1; s1_opcode = BR;
      settle();
      chk("R2", "s0 station busy", s0_go, 0);
      chk("R3", "s1 held behind s0", s1_go, 0);
      @(posedge clk); #1;
      alu_rdy = 1; rob_avail0 = 0;
      settle();
      chk("R2", "s0 no rob", s0_go, 0);
      chk("R3", "s1 held no rob0", s1_go, 0);
   endtask

   task automatic t_dual();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = RR; s0_rd = 5'd9;
      s1_valid = 1; s1_opcode = LD; s1_rd = 5'd10; s1_rs1 = 5'd3;
      settle();
      chk("R4", "dual s0_go", s0_go, 1);
      chk("R4", "dual s1_go", s1_go, 1);
      chk("R6", "s0 tag", s0_tag, 3'd5);
      chk("R6", "s1 tag", s1_tag, 3'd6);
      chk("R10", "we0", rs_we0, 1);
      chk("R10", "rd0", rs_rd0, 5'd9);
      chk("R10", "tag0", rs_tag0, 3'd5);
      chk("R10", "we1", rs_we1, 1);
      chk("R10", "rd1", rs_rd1, 5'd10);
      chk("R10", "tag1", rs_tag1, 3'd6);
   endtask

   task automatic t_conflict();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = RR; s1_valid = 1; s1_opcode = IMM;
      settle();
      chk("R5", "same station s0", s0_go, 1);
      chk("R5", "same station s1", s1_go, 0);
      @(posedge clk); #1;
      s1_opcode = ST; ls_rdy = 0;
      settle();
      chk("R4", "s1 station busy", s1_go, 0);
      chk("R4", "s0 still goes", s0_go, 1);
      @(posedge clk); #1;
      ls_rdy = 1; rob_avail1 = 0;
      settle();
      chk("R4", "s1 no rob1", s1_go, 0);
      @(posedge clk); #1;
      rob_avail1 = 1; s1_valid = 0;
      settle();
      chk("R4", "s1 invalid", s1_go, 0);
   endtask

   task automatic t_fwd();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = LD; s0_rd = 5'd5; s0_rs1 = 5'd2;
      s1_valid = 1; s1_opcode = RR; s1_rd = 5'd7; s1_rs1 = 5'd5; s1_rs2 = 5'd5;
      settle();
      chk("R7", "both go", {s0_go, s1_go}, 2'b11);
      chk("R7", "a rdy", s1_a_rdy_o, 0);
      chk("R7", "a tag", s1_a_tag_o, 3'd5);
      chk("R7", "a val", s1_a_val_o, 0);
      chk("R7", "b rdy", s1_b_rdy_o, 0);
      chk("R7", "b tag", s1_b_tag_o, 3'd5);
      @(posedge clk); #1;
      s1_rs1 = 5'd6; s1_a_rdy = 0; s1_a_tag = 3'd2;
      settle();
      chk("R11", "a rdy kept", s1_a_rdy_o, 0);
      chk("R11", "a tag kept", s1_a_tag_o, 3'd2);
      chk("R11", "a val kept", s1_a_val_o, 32'h33);
      chk("R11", "s0 a val", s0_a_val_o, 32'h11);
      chk("R11", "s0 a tag", s0_a_tag_o, 3'd1);
   endtask

   task automatic t_x0();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = LD; s0_rd = 5'd0;
      s1_valid = 1; s1_opcode = RR; s1_rd = 5'd0; s1_rs1 = 5'd0; s1_rs2 = 5'd0;
      settle();
      chk("R8", "both go", {s0_go, s1_go}, 2'b11);
      chk("R8", "no fwd a", s1_a_rdy_o, 1);
      chk("R8", "val a", s1_a_val_o, 32'h33);
      chk("R8", "no fwd b", s1_b_rdy_o, 1);
      chk("R8", "we0 off", rs_we0, 0);
      chk("R8", "we1 off", rs_we1, 0);
   endtask

   task automatic t_unused();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = LUI; s0_rd = 5'd3;
      s0_a_rdy = 0; s0_b_rdy = 0;
      s1_valid = 1; s1_opcode = JAL; s1_rd = 5'd1; s1_rs1 = 5'd3; s1_rs2 = 5'd3;
      s1_a_rdy = 0; s1_b_rdy = 0;
      settle();
      chk("R9", "lui rs1", s0_a_rdy_o, 1);
      chk("R9", "lui rs2", s0_b_rdy_o, 1);
      chk("R9", "jal rs1 no fwd", s1_a_rdy_o, 1);
      chk("R9", "jal rs2 no fwd", s1_b_rdy_o, 1);
      @(posedge clk); #1;
      s1_opcode = LD; s1_rs1 = 5'd3; s1_rs2 = 5'd3;
      settle();
      chk("R7", "load rs1 fwd", s1_a_rdy_o, 0);
      chk("R9", "load rs2 unused", s1_b_rdy_o, 1);
   endtask

   task automatic t_nowrite();
      @(posedge clk); #1;
      idle(); s0_valid = 1; s0_opcode = ST; s0_rd = 5'd8;
      s1_valid = 1; s1_opcode = BR; s1_rd = 5'd9; s1_rs1 = 5'd8; s1_a_rdy = 1;
      settle();
      chk("R10", "store no we", rs_we0, 0);
      chk("R10", "branch no we", rs_we1, 0);
      chk("R7", "store rd not forwarded", s1_a_rdy_o, 1);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_class();
            t_block();
            t_dual();
            t_conflict();
            t_fwd();
            t_x0();
            t_unused();
            t_nowrite();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule